// File: doc/BRIEF.md
# Pipeline Hazard Stall and Operand Bypass Unit

This unit decides, every cycle, how the instruction sitting in decode of a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback) obtains its source operands. It keeps a small tag pipeline that mirrors the execute, memory and writeback stages. Each tag holds the destination index, a write flag and a result-class flag for the instruction in that stage. The class flag says whether the result exists from execute onward, as for add and subtract, or only once the instruction reaches writeback, as for multiply.

For each source register the unit compares the index against the three tags and picks the youngest matching producer. If that producer's value already exists, the unit forwards it. If it does not, the unit asserts a stall: fetch and decode hold their contents and a no-op bubble enters execute. A build parameter removes forwarding altogether. In that build, any dependency holds decode until the producer has retired and its value can be read from the register file.

The register file, the ALU and the multiplier sit outside the unit. The unit receives the register-file read data and the per-stage result buses, and returns the resolved operands together with the stall and bubble controls.

Top module: `hazard_fwd_unit`

## Requirements
- R1: A source index of 0 never causes a stall and is never forwarded; its operand is always the register-file read value, even if an in-flight instruction writes index 0.
- R2: With forwarding enabled, a source that depends on an early-class producer (class flag 0) in execute, memory or writeback gets that producer's result with no stall, taken from ex_result_i, mem_result_i or wb_result_i respectively.
- R3: With forwarding enabled, a source that depends on a late-class producer (class flag 1) stalls while the producer is in execute or memory, and gets wb_result_i with no stall once the producer is in writeback. A multiply followed at once by a dependent instruction therefore stalls exactly 2 cycles.
- R4: When several stages write the source register, the youngest one (execute before memory before writeback) decides both the forwarded value and whether a stall is needed.
- R5: While stall_o is high, bubble_o is high and the following cycle holds a no-op in execute, so the held instruction enters execute only after the stall clears. The older instructions keep advancing.
- R6: With forwarding disabled (FWD_EN=0), any dependency on a writing instruction in execute, memory or writeback stalls. An add followed at once by a dependent instruction stalls exactly 3 cycles, after which the operand comes from the register file.
- R7: No stall is raised and the operands equal the register-file values when no source matches: different indices, a producer with its write flag at 0, a source marked unused, or dec_valid_i at 0.
- R8: Independent multiplies issued back to back (4 in a row) cause no stall.
- R9: After reset all tag stages are empty: no stall, and operands come from the register file.
- R10: The two sources are resolved independently: each may forward from a different stage, and a stall is raised if either source needs one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dec_valid_i | input | 1 | Decode holds a valid instruction |
| dec_rs1_i | input | AW | First source index |
| dec_rs1_use_i | input | 1 | First source is read |
| dec_rs2_i | input | AW | Second source index |
| dec_rs2_use_i | input | 1 | Second source is read |
| dec_rd_i | input | AW | Destination index of the decode instruction |
| dec_we_i | input | 1 | Decode instruction writes a register |
| dec_late_i | input | 1 | Result class: 0 ready in execute, 1 ready only in writeback |
| rf_rs1_i | input | XLEN | Register-file read data for the first source |
| rf_rs2_i | input | XLEN | Register-file read data for the second source |
| ex_result_i | input | XLEN | Result of the instruction in execute |
| mem_result_i | input | XLEN | Result of the instruction in memory |
| wb_result_i | input | XLEN | Result of the instruction in writeback |
| op1_o | output | XLEN | Resolved first operand |
| op2_o | output | XLEN | Resolved second operand |
| stall_o | output | 1 | Hold fetch and decode |
| bubble_o | output | 1 | Insert a no-op into execute |

## Verification
Add-then-dependent sequences at distances of one, two and three instructions separate forwarding from execute, memory and writeback. The same spacing with multiplies separates stall cycles from a writeback forward and fixes the two-cycle penalty. Chains that write one register twice, or that mix an early older writer with a late younger one, show whether the youngest producer is chosen. A pair of sources pointing at different producers shows that each source is resolved on its own. Four independent multiplies, writes to index 0 and unused sources are the non-dependencies that must not stall, and a second instance built without forwarding must give the three-cycle stall on the same add sequence.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int N_STAGES = 3;  // execute, memory, writeback
  localparam int ST_EX  = 0;
  localparam int ST_MEM = 1;
  localparam int ST_WB  = 2;
  localparam int N_SRC  = 2;
endpackage

// File: rtl/hz_stage_track.sv
module hz_stage_track
  import hz_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         stall_i,
  input  logic                         dec_valid_i,
  input  logic                         dec_we_i,
  input  logic [AW-1:0]                dec_rd_i,
  input  logic                         dec_late_i,
  output logic [N_STAGES-1:0]          st_vld_o,
  output logic [N_STAGES-1:0]          st_we_o,
  output logic [N_STAGES-1:0][AW-1:0]  st_rd_o,
  output logic [N_STAGES-1:0]          st_late_o
);
  logic [N_STAGES-1:0]         vld_q, we_q, late_q;
  logic [N_STAGES-1:0][AW-1:0] rd_q;
  logic                        enter;

  // a stalled decode slot turns into a bubble in execute
  assign enter = dec_valid_i & ~stall_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      we_q   <= '0;
      late_q <= '0;
      rd_q   <= '0;
    end else begin
      vld_q[ST_EX]  <= enter;
      we_q[ST_EX]   <= enter & dec_we_i;
      late_q[ST_EX] <= enter & dec_late_i;
      rd_q[ST_EX]   <= enter ? dec_rd_i : '0;
      for (int k = 1; k < N_STAGES; k++) begin
        vld_q[k]  <= vld_q[k-1];
        we_q[k]   <= we_q[k-1];
        late_q[k] <= late_q[k-1];
        rd_q[k]   <= rd_q[k-1];
      end
    end
  end

  assign st_vld_o  = vld_q;
  assign st_we_o   = we_q;
  assign st_late_o = late_q;
  assign st_rd_o   = rd_q;
endmodule

// File: rtl/hz_src_resolve.sv
module hz_src_resolve
  import hz_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int AW     = 5,
  parameter bit FWD_EN = 1'b1
) (
  input  logic                          use_i,
  input  logic [AW-1:0]                 rs_i,
  input  logic [N_STAGES-1:0]           st_vld_i,
  input  logic [N_STAGES-1:0]           st_we_i,
  input  logic [N_STAGES-1:0][AW-1:0]   st_rd_i,
  input  logic [N_STAGES-1:0]           st_late_i,
  input  logic [N_STAGES-1:0][XLEN-1:0] st_res_i,
  input  logic [XLEN-1:0]               rf_val_i,
  output logic [XLEN-1:0]               val_o,
  output logic                          hold_o
);
  localparam int SW = $clog2(N_STAGES);

  logic [N_STAGES-1:0] match;
  logic [SW-1:0]       yk;
  logic                found;

  for (genvar k = 0; k < N_STAGES; k++) begin : g_cmp
    assign match[k] = use_i & (rs_i != '0) & st_vld_i[k] & st_we_i[k] &
                      (st_rd_i[k] == rs_i);
  end

  // youngest producer wins: scan from oldest so the last hit is nearest execute
  always_comb begin
    yk    = SW'(N_STAGES-1);
    found = 1'b0;
    for (int k = N_STAGES-1; k >= 0; k--) begin
      if (match[k]) begin
        yk    = SW'(k);
        found = 1'b1;
      end
    end
  end

  if (FWD_EN) begin : g_fwd
    logic ready;
    assign ready  = ~st_late_i[yk] | (yk == SW'(ST_WB));
    assign hold_o = found & ~ready;
    assign val_o  = (found && ready) ? st_res_i[yk] : rf_val_i;
  end else begin : g_nofwd
    assign hold_o = found;
    assign val_o  = rf_val_i;
  end
endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit
  import hz_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int AW     = 5,
  parameter bit FWD_EN = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            dec_valid_i,
  input  logic [AW-1:0]   dec_rs1_i,
  input  logic            dec_rs1_use_i,
  input  logic [AW-1:0]   dec_rs2_i,
  input  logic            dec_rs2_use_i,
  input  logic [AW-1:0]   dec_rd_i,
  input  logic            dec_we_i,
  input  logic            dec_late_i,
  input  logic [XLEN-1:0] rf_rs1_i,
  input  logic [XLEN-1:0] rf_rs2_i,
  input  logic [XLEN-1:0] ex_result_i,
  input  logic [XLEN-1:0] mem_result_i,
  input  logic [XLEN-1:0] wb_result_i,
  output logic [XLEN-1:0] op1_o,
  output logic [XLEN-1:0] op2_o,
  output logic            stall_o,
  output logic            bubble_o
);
  logic [N_STAGES-1:0]           st_vld, st_we, st_late;
  logic [N_STAGES-1:0][AW-1:0]   st_rd;
  logic [N_STAGES-1:0][XLEN-1:0] st_res;
  logic [N_SRC-1:0][AW-1:0]      src_idx;
  logic [N_SRC-1:0]              src_use, src_hold;
  logic [N_SRC-1:0][XLEN-1:0]    src_rf, src_val;

  assign st_res[ST_EX]  = ex_result_i;
  assign st_res[ST_MEM] = mem_result_i;
  assign st_res[ST_WB]  = wb_result_i;

  assign src_idx[0] = dec_rs1_i;
  assign src_idx[1] = dec_rs2_i;
  assign src_use[0] = dec_valid_i & dec_rs1_use_i;
  assign src_use[1] = dec_valid_i & dec_rs2_use_i;
  assign src_rf[0]  = rf_rs1_i;
  assign src_rf[1]  = rf_rs2_i;

  hz_stage_track #(.AW(AW)) u_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .stall_i     (stall_o),
    .dec_valid_i (dec_valid_i),
    .dec_we_i    (dec_we_i),
    .dec_rd_i    (dec_rd_i),
    .dec_late_i  (dec_late_i),
    .st_vld_o    (st_vld),
    .st_we_o     (st_we),
    .st_rd_o     (st_rd),
    .st_late_o   (st_late)
  );

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    hz_src_resolve #(.XLEN(XLEN), .AW(AW), .FWD_EN(FWD_EN)) u_res (
      .use_i     (src_use[s]),
      .rs_i      (src_idx[s]),
      .st_vld_i  (st_vld),
      .st_we_i   (st_we),
      .st_rd_i   (st_rd),
      .st_late_i (st_late),
      .st_res_i  (st_res),
      .rf_val_i  (src_rf[s]),
      .val_o     (src_val[s]),
      .hold_o    (src_hold[s])
    );
  end

  assign op1_o    = src_val[0];
  assign op2_o    = src_val[1];
  assign stall_o  = dec_valid_i & (|src_hold);
  assign bubble_o = stall_o;
endmodule

// File: rtl/hz_checker.sv
module hz_checker #(
  parameter int XLEN   = 32,
  parameter int AW     = 5,
  parameter bit FWD_EN = 1'b1
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            dec_valid_i,
  input logic [AW-1:0]   dec_rs1_i,
  input logic            dec_rs1_use_i,
  input logic [AW-1:0]   dec_rs2_i,
  input logic            dec_rs2_use_i,
  input logic [XLEN-1:0] rf_rs1_i,
  input logic [XLEN-1:0] rf_rs2_i,
  input logic [XLEN-1:0] ex_result_i,
  input logic [XLEN-1:0] op1_o,
  input logic [XLEN-1:0] op2_o,
  input logic            stall_o,
  input logic            bubble_o,
  input logic [2:0]      st_vld,
  input logic [2:0]      st_we,
  input logic [2:0][AW-1:0] st_rd,
  input logic [2:0]      st_late
);
  logic rs1_hits_ex;
  assign rs1_hits_ex = dec_valid_i && dec_rs1_use_i && (dec_rs1_i != '0) &&
                       st_vld[0] && st_we[0] && (st_rd[0] == dec_rs1_i);

  p_x0_only_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_i && (!dec_rs1_use_i || dec_rs1_i == '0) &&
     (!dec_rs2_use_i || dec_rs2_i == '0))
    |-> (!stall_o && op1_o == rf_rs1_i && op2_o == rf_rs2_i));

  p_early_ex_fwd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (FWD_EN && rs1_hits_ex && !st_late[0]) |-> (op1_o == ex_result_i));

  p_late_ex_stall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rs1_hits_ex && st_late[0]) |-> stall_o);

  p_bubble_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> bubble_o);

  p_bubble_ex_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> !st_vld[0]);

  p_nofwd_wb_stall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!FWD_EN && dec_valid_i && dec_rs1_use_i && dec_rs1_i != '0 &&
     st_vld[2] && st_we[2] && st_rd[2] == dec_rs1_i) |-> stall_o);

  p_idle_no_stall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_valid_i |-> !stall_o);
endmodule

bind hazard_fwd_unit hz_checker #(.XLEN(XLEN), .AW(AW), .FWD_EN(FWD_EN)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .dec_valid_i   (dec_valid_i),
  .dec_rs1_i     (dec_rs1_i),
  .dec_rs1_use_i (dec_rs1_use_i),
  .dec_rs2_i     (dec_rs2_i),
  .dec_rs2_use_i (dec_rs2_use_i),
  .rf_rs1_i      (rf_rs1_i),
  .rf_rs2_i      (rf_rs2_i),
  .ex_result_i   (ex_result_i),
  .op1_o         (op1_o),
  .op2_o         (op2_o),
  .stall_o       (stall_o),
  .bubble_o      (bubble_o),
  .st_vld        (st_vld),
  .st_we         (st_we),
  .st_rd         (st_rd),
  .st_late       (st_late)
);

// File: tb/sim_hazard_fwd_unit.sv
`timescale 1ns/1ps
module sim_hazard_fwd_unit;
  localparam int XLEN = 32;
  localparam int AW   = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic            rst_n;
  logic            dv, u1, u2, we, late;
  logic [AW-1:0]   rs1, rs2, rd;
  logic [XLEN-1:0] rf1, rf2, exr, memr, wbr;
  logic [XLEN-1:0] op1_a, op2_a, op1_b, op2_b;
  logic            st_a, bb_a, st_b, bb_b;

  hazard_fwd_unit #(.XLEN(XLEN), .AW(AW), .FWD_EN(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .dec_valid_i(dv),
    .dec_rs1_i(rs1), .dec_rs1_use_i(u1), .dec_rs2_i(rs2), .dec_rs2_use_i(u2),
    .dec_rd_i(rd), .dec_we_i(we), .dec_late_i(late),
    .rf_rs1_i(rf1), .rf_rs2_i(rf2), .ex_result_i(exr), .mem_result_i(memr),
    .wb_result_i(wbr), .op1_o(op1_a), .op2_o(op2_a), .stall_o(st_a), .bubble_o(bb_a));

  hazard_fwd_unit #(.XLEN(XLEN), .AW(AW), .FWD_EN(1'b0)) u1_nofwd (
    .clk_i(clk), .rst_ni(rst_n), .dec_valid_i(dv),
    .dec_rs1_i(rs1), .dec_rs1_use_i(u1), .dec_rs2_i(rs2), .dec_rs2_use_i(u2),
    .dec_rd_i(rd), .dec_we_i(we), .dec_late_i(late),
    .rf_rs1_i(rf1), .rf_rs2_i(rf2), .ex_result_i(exr), .mem_result_i(memr),
    .wb_result_i(wbr), .op1_o(op1_b), .op2_o(op2_b), .stall_o(st_b), .bubble_o(bb_b));

  typedef struct {
    bit              v;
    bit              we;
    logic [AW-1:0]   rd;
    bit              late;
    logic [XLEN-1:0] val;
  } slot_t;

  typedef struct {
    bit              stall;
    logic [XLEN-1:0] op1;
    logic [XLEN-1:0] op2;
    string           req;
  } exp_t;

  slot_t           m [3];
  logic [XLEN-1:0] rf [32];
  exp_t            q [$];
  int              checks = 0;
  int              failures = 0;
  bit              fwd_mode = 1'b1;
  string           cur_req = "R9";
  int              seq = 0;

  task automatic clear_model();
    for (int k = 0; k < 3; k++) m[k] = '{v:0, we:0, rd:'0, late:0, val:'0};
    for (int i = 0; i < 32; i++) rf[i] = (i == 0) ? '0 : 32'hA000_0000 + XLEN'(i);
  endtask

  // expected operand and hold for one source, from the requirements
  task automatic resolve(input bit use_s, input logic [AW-1:0] rs,
                         output logic [XLEN-1:0] val, output bit hold);
    int yk = -1;
    val  = rf[rs];
    hold = 1'b0;
    if (use_s && rs != '0) begin
      for (int k = 2; k >= 0; k--)
        if (m[k].v && m[k].we && m[k].rd == rs) yk = k;
      if (yk >= 0) begin
        if (fwd_mode && (!m[yk].late || yk == 2)) val = m[yk].val;
        else hold = 1'b1;
      end
    end
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [XLEN-1:0] got, input logic [XLEN-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s got=%h exp=%h", req, what, got, exp);
    end
  endtask

  // drive one decode instruction until it leaves decode; ns = stall cycles
  task automatic issue(input bit v, input logic [AW-1:0] a1, input bit e1,
                       input logic [AW-1:0] a2, input bit e2,
                       input logic [AW-1:0] d, input bit w, input bit lt,
                       output int ns);
    logic [XLEN-1:0] myval, v1, v2;
    bit h1, h2;
    exp_t it;
    seq++;
    myval = 32'h0100_0000 + XLEN'(seq) * 32'h111;
    ns = 0;
    forever begin
      @(negedge clk);
      dv = v; rs1 = a1; u1 = e1; rs2 = a2; u2 = e2; rd = d; we = w; late = lt;
      rf1  = rf[a1];
      rf2  = rf[a2];
      exr  = m[0].late ? 32'hDEAD_0000 : m[0].val;
      memr = m[1].late ? 32'hDEAD_1111 : m[1].val;
      wbr  = m[2].val;
      resolve(v && e1, a1, v1, h1);
      resolve(v && e2, a2, v2, h2);
      it.stall = v && (h1 || h2);
      it.op1 = v1; it.op2 = v2; it.req = cur_req;
      q.push_back(it);
      @(posedge clk);
      if (m[2].v && m[2].we && m[2].rd != '0) rf[m[2].rd] = m[2].val;
      m[2] = m[1];
      m[1] = m[0];
      if (it.stall || !v) m[0] = '{v:0, we:0, rd:'0, late:0, val:'0};
      else m[0] = '{v:1, we:w, rd:d, late:lt, val:myval};
      if (!it.stall) break;
      ns++;
    end
  endtask

  task automatic nop();
    int ns;
    issue(1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0, ns);
  endtask

  task automatic drain();
    for (int i = 0; i < 4; i++) nop();
  endtask

  // scoreboard monitor
  initial begin
    exp_t it;
    logic [XLEN-1:0] o1, o2;
    logic s, b;
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        it = q.pop_front();
        o1 = fwd_mode ? op1_a : op1_b;
        o2 = fwd_mode ? op2_a : op2_b;
        s  = fwd_mode ? st_a : st_b;
        b  = fwd_mode ? bb_a : bb_b;
        chk(s == it.stall, it.req, "stall", XLEN'(s), XLEN'(it.stall));
        chk(b == it.stall, "R5", "bubble", XLEN'(b), XLEN'(it.stall));
        if (!it.stall) begin
          chk(o1 == it.op1, it.req, "op1", o1, it.op1);
          chk(o2 == it.op2, it.req, "op2", o2, it.op2);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    dv = 0; u1 = 0; u2 = 0; we = 0; late = 0; rs1 = '0; rs2 = '0; rd = '0;
    rf1 = '0; rf2 = '0; exr = '0; memr = '0; wbr = '0;
    clear_model();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    int ns, tot;
    do_reset();

    // ---------------- forwarding build ----------------
    fwd_mode = 1'b1;
    cur_req = "R9";
    issue(1, 5'd2, 1, 5'd3, 1, 5'd4, 1, 0, ns);
    chk(ns == 0, "R9", "stall count after reset", XLEN'(ns), 0);
    drain();

    cur_req = "R7";
    issue(1, 5'd2, 1, 5'd3, 1, 5'd5, 0, 0, ns);   // no write
    issue(1, 5'd5, 1, 5'd6, 1, 5'd7, 1, 0, ns);   // reads x5: writer had we=0
    chk(ns == 0, "R7", "no-write producer stall", XLEN'(ns), 0);
    issue(1, 5'd7, 0, 5'd7, 0, 5'd8, 1, 0, ns);   // sources unused
    chk(ns == 0, "R7", "unused source stall", XLEN'(ns), 0);
    drain();

    cur_req = "R2";
    issue(1, 5'd1, 1, 5'd2, 1, 5'd10, 1, 0, ns);  // add x10
    issue(1, 5'd10, 1, 5'd3, 1, 5'd11, 1, 0, ns); // dep from execute
    chk(ns == 0, "R2", "add->dep stall", XLEN'(ns), 0);
    nop();
    issue(1, 5'd2, 1, 5'd11, 1, 5'd12, 1, 0, ns); // dep from memory
    nop(); nop();
    issue(1, 5'd12, 1, 5'd1, 0, 5'd13, 1, 0, ns); // dep from writeback
    chk(ns == 0, "R2", "wb distance stall", XLEN'(ns), 0);
    drain();

    cur_req = "R3";
    issue(1, 5'd1, 1, 5'd2, 1, 5'd14, 1, 1, ns);  // mul x14
    issue(1, 5'd14, 1, 5'd3, 1, 5'd15, 1, 0, ns);
    chk(ns == 2, "R3", "mul->dep stall cycles", XLEN'(ns), 2);
    drain();
    issue(1, 5'd1, 1, 5'd2, 1, 5'd16, 1, 1, ns);  // mul x16
    nop();
    issue(1, 5'd3, 1, 5'd16, 1, 5'd17, 1, 0, ns); // mul in memory
    chk(ns == 1, "R3", "mul gap1 stall cycles", XLEN'(ns), 1);
    drain();

    cur_req = "R8";
    tot = 0;
    for (int i = 0; i < 4; i++) begin
      issue(1, 5'd1, 1, 5'd2, 1, AW'(20 + i), 1, 1, ns);
      tot += ns;
    end
    chk(tot == 0, "R8", "independent mul stalls", XLEN'(tot), 0);
    drain();

    cur_req = "R4";
    issue(1, 5'd1, 1, 5'd2, 1, 5'd11, 1, 0, ns);
    issue(1, 5'd3, 1, 5'd4, 1, 5'd11, 1, 0, ns);
    issue(1, 5'd11, 1, 5'd11, 1, 5'd12, 1, 0, ns); // youngest value
    chk(ns == 0, "R4", "double writer stall", XLEN'(ns), 0);
    drain();
    issue(1, 5'd1, 1, 5'd2, 1, 5'd13, 1, 0, ns);   // add x13 (older)
    issue(1, 5'd1, 1, 5'd2, 1, 5'd13, 1, 1, ns);   // mul x13 (younger)
    issue(1, 5'd13, 1, 5'd0, 0, 5'd14, 1, 0, ns);
    chk(ns == 2, "R4", "late young writer stall", XLEN'(ns), 2);
    drain();

    cur_req = "R10";
    issue(1, 5'd1, 1, 5'd2, 1, 5'd25, 1, 0, ns);   // add x25
    issue(1, 5'd1, 1, 5'd2, 1, 5'd26, 1, 1, ns);   // mul x26
    issue(1, 5'd25, 1, 5'd26, 1, 5'd27, 1, 0, ns); // rs1 ready, rs2 not
    chk(ns == 2, "R10", "mixed source stall", XLEN'(ns), 2);
    drain();
    issue(1, 5'd1, 1, 5'd2, 1, 5'd28, 1, 0, ns);
    issue(1, 5'd1, 1, 5'd2, 1, 5'd29, 1, 0, ns);
    issue(1, 5'd29, 1, 5'd28, 1, 5'd30, 1, 0, ns); // ex and mem forwards
    chk(ns == 0, "R10", "dual forward stall", XLEN'(ns), 0);
    drain();

    cur_req = "R1";
    issue(1, 5'd1, 1, 5'd2, 1, 5'd0, 1, 1, ns);    // mul writing x0
    issue(1, 5'd0, 1, 5'd0, 1, 5'd3, 1, 0, ns);
    chk(ns == 0, "R1", "x0 source stall", XLEN'(ns), 0);
    drain();

    cur_req = "R5";
    issue(1, 5'd1, 1, 5'd2, 1, 5'd18, 1, 1, ns);   // mul x18
    issue(1, 5'd18, 1, 5'd2, 1, 5'd19, 1, 0, ns);  // stalls, then add x19
    issue(1, 5'd19, 1, 5'd18, 1, 5'd20, 1, 0, ns); // x19 from ex, x18 from mem? no: mul retired
    chk(ns == 0, "R5", "post-stall forward stall", XLEN'(ns), 0);
    drain();

    // ---------------- build without forwarding ----------------
    do_reset();
    fwd_mode = 1'b0;
    cur_req = "R6";
    issue(1, 5'd1, 1, 5'd2, 1, 5'd10, 1, 0, ns);
    issue(1, 5'd10, 1, 5'd3, 1, 5'd11, 1, 0, ns);
    chk(ns == 3, "R6", "add->dep stall cycles", XLEN'(ns), 3);
    drain();
    issue(1, 5'd1, 1, 5'd2, 1, 5'd12, 1, 1, ns);
    issue(1, 5'd4, 1, 5'd12, 1, 5'd13, 1, 0, ns);
    chk(ns == 3, "R6", "mul->dep stall cycles", XLEN'(ns), 3);
    drain();
    cur_req = "R8";
    tot = 0;
    for (int i = 0; i < 4; i++) begin
      issue(1, 5'd1, 1, 5'd2, 1, AW'(20 + i), 1, 1, ns);
      tot += ns;
    end
    chk(tot == 0, "R8", "independent mul stalls no-fwd", XLEN'(tot), 0);
    drain();

    @(negedge clk);
    #2;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule